// File: doc/BRIEF.md
# Three-Lane 7:1 Pixel Serializer

This block turns one 21-bit pixel word per pixel clock period into three serial data lanes. Each lane carries seven bits per period. A fourth lane carries a forwarded copy of the pixel clock. The word is made of 18 colour bits (6 each for red, green and blue) and 3 timing bits (data enable, frame sync, line sync).

The serializer runs on a bit clock at seven times the pixel rate. The bit clock comes from an external multiplier and enters the block as `clk_i`. The pixel clock enters as `pix_clk_i` and is sampled on the bit clock. A static strap, `strobe_sel_i`, chooses which pixel clock edge captures the parallel word:
- High selects the rising edge.
- Low selects the falling edge. This is also the board default, because the strap is pulled low when left open.

The captured word waits in a shadow register. It is moved into the lane shifters only at the pixel clock rising edge, which is the bit-0 slot, so a serial word is never split between two input words.

An active-low power-down input releases every lane, the clock lane included, to high impedance.

Top module: `pix_ser7_tx`

## Requirements
- R1: A rising pixel clock edge starts a new period. In the bit-clock cycle that follows that edge, every lane shows slot 0. Slot k appears k bit-clock cycles later, for k from 0 to 6. Each lane sends its seven bits LSB first.
- R2: Data lane 0 carries word bits 0..6. Lane 1 carries bits 7..13. Lane 2 carries bits 14..20. In slot k, lane n shows word bit 7*n+k.
- R3: While driven, the clock lane shows 1 in slots 0 to 3 and 0 in slots 4 to 6 of every period.
- R4: With `strobe_sel_i`=1, the word present at the pixel clock rising edge is captured. That word is sent in the next period. Data changes later in the same period are ignored.
- R5: With `strobe_sel_i`=0, the word present at the pixel clock falling edge is captured. That word is sent in the period that starts at the following rising edge.
- R6: While `pwr_dn_ni`=0, `lane_drv_en_o` is 0 and all four lanes are high impedance.
- R7: After power-down is released, the lanes stay undriven through the first period. They are driven from the period that carries the first word captured while powered up.
- R8: During and after reset, `lane_drv_en_o` is 0 until a word captured after reset has been loaded.
- R9: A data change at the input during a period does not alter the bits being sent in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_clk_i | input | 1 | Pixel clock, sampled on `clk_i` |
| strobe_sel_i | input | 1 | Capture edge select: 1 = rising, 0 = falling |
| pwr_dn_ni | input | 1 | Power-down, active low |
| data_i | input | 21 | Parallel pixel word: colour and timing bits |
| lane_o | output | 3 | Serial data lanes, tri-state |
| clk_lane_o | output | 1 | Forwarded clock lane, tri-state |
| lane_drv_en_o | output | 1 | High while the lane drivers are active |

## Verification
The bench builds the block with its default three lanes of seven bits. With that size, a walking one across all 21 word positions plus dense alternating patterns checks the position of every bit on every lane.

Both strap settings are swept. Each period carries two inputs: one word present at the rising edge and its complement applied before the falling edge. The captured word therefore shows which edge was used, and also confirms that the serial stream is not torn.

A power-down period and its release are placed inside each sweep. These cover the driver-enable sequencing.

// File: rtl/pix_ser7_pkg.sv
package pix_ser7_pkg;
  localparam int unsigned DEF_LANES = 3;
  localparam int unsigned DEF_BITS  = 7;

  // number of high slots in the forwarded clock pattern
  function automatic int unsigned hi_slots(input int unsigned bits);
    return (bits + 1) / 2;
  endfunction
endpackage

// File: rtl/pix_ser7_edge.sv
module pix_ser7_edge #(
  parameter int unsigned WORD = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pix_clk_i,
  input  logic            strobe_sel_i,
  input  logic            pwr_dn_ni,
  input  logic [WORD-1:0] data_i,
  output logic            load_o,
  output logic            cap_o,
  output logic [WORD-1:0] shadow_o,
  output logic            captured_o
);
  logic            pclk_q;
  logic            rise, fall;
  logic [WORD-1:0] shadow_q;
  logic            captured_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_q <= 1'b0;
    else         pclk_q <= pix_clk_i;
  end

  assign rise  = pix_clk_i & ~pclk_q;
  assign fall  = ~pix_clk_i & pclk_q;
  assign cap_o = strobe_sel_i ? rise : fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    shadow_q <= '0;
    else if (cap_o) shadow_q <= data_i;
  end

  // marks a shadow word taken while powered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         captured_q <= 1'b0;
    else if (!pwr_dn_ni) captured_q <= 1'b0;
    else if (cap_o)      captured_q <= 1'b1;
  end

  assign load_o     = rise;
  assign shadow_o   = shadow_q;
  assign captured_o = captured_q;
endmodule

// File: rtl/pix_ser7_lane.sv
module pix_ser7_lane #(
  parameter int unsigned BITS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] par_i,
  output logic            ser_o
);
  logic [BITS-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (load_i) shift_q <= par_i;
    else             shift_q <= {1'b0, shift_q[BITS-1:1]};
  end

  assign ser_o = shift_q[0];
endmodule

// File: rtl/pix_ser7_outctl.sv
module pix_ser7_outctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_dn_ni,
  input  logic load_i,
  input  logic captured_i,
  output logic drv_en_o
);
  logic loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         loaded_q <= 1'b0;
    else if (!pwr_dn_ni) loaded_q <= 1'b0;
    else if (load_i)     loaded_q <= captured_i;
  end

  assign drv_en_o = pwr_dn_ni & loaded_q;
endmodule

// File: rtl/pix_ser7_tx.sv
module pix_ser7_tx #(
  parameter int unsigned LANES = pix_ser7_pkg::DEF_LANES,
  parameter int unsigned BITS  = pix_ser7_pkg::DEF_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pix_clk_i,
  input  logic                  strobe_sel_i,
  input  logic                  pwr_dn_ni,
  input  logic [LANES*BITS-1:0] data_i,
  output logic [LANES-1:0]      lane_o,
  output logic                  clk_lane_o,
  output logic                  lane_drv_en_o
);
  localparam int unsigned WORD = LANES * BITS;
  localparam int unsigned HI   = pix_ser7_pkg::hi_slots(BITS);
  localparam logic [BITS-1:0] CLK_PAT = BITS'((1 << HI) - 1);

  logic            load_w, cap_w, captured_w, drv_en_w, clk_ser_w;
  logic [WORD-1:0] shadow_w;
  logic [LANES-1:0] ser_w;

  pix_ser7_edge #(.WORD(WORD)) u_edge (
    .clk_i, .rst_ni, .pix_clk_i, .strobe_sel_i, .pwr_dn_ni, .data_i,
    .load_o(load_w), .cap_o(cap_w), .shadow_o(shadow_w), .captured_o(captured_w)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    pix_ser7_lane #(.BITS(BITS)) u_lane (
      .clk_i, .rst_ni, .load_i(load_w),
      .par_i(shadow_w[n*BITS +: BITS]), .ser_o(ser_w[n])
    );
  end

  pix_ser7_lane #(.BITS(BITS)) u_clk_lane (
    .clk_i, .rst_ni, .load_i(load_w), .par_i(CLK_PAT), .ser_o(clk_ser_w)
  );

  pix_ser7_outctl u_outctl (
    .clk_i, .rst_ni, .pwr_dn_ni, .load_i(load_w),
    .captured_i(captured_w), .drv_en_o(drv_en_w)
  );

  assign lane_o        = drv_en_w ? ser_w : {LANES{1'bz}};
  assign clk_lane_o    = drv_en_w ? clk_ser_w : 1'bz;
  assign lane_drv_en_o = drv_en_w;
endmodule

// File: rtl/pix_ser7_tx_chk.sv
module pix_ser7_tx_chk #(
  parameter int unsigned WORD = 21
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pix_clk_i,
  input logic            strobe_sel_i,
  input logic            pwr_dn_ni,
  input logic            lane_drv_en_o,
  input logic            load_w,
  input logic            cap_w,
  input logic            clk_ser_w,
  input logic [WORD-1:0] shadow_w
);
  AST_LOAD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |-> pix_clk_i); // R1
  AST_CLK_SLOT0_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> clk_ser_w); // R3
  AST_RISE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_sel_i && cap_w) |-> pix_clk_i); // R4
  AST_FALL_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_sel_i && cap_w) |-> !pix_clk_i); // R5
  AST_PWRDN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |-> !lane_drv_en_o); // R6
  AST_EN_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lane_drv_en_o) |-> $past(load_w)); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_w |=> $stable(shadow_w)); // R9
endmodule

bind pix_ser7_tx pix_ser7_tx_chk #(.WORD(LANES*BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_clk_i(pix_clk_i),
  .strobe_sel_i(strobe_sel_i), .pwr_dn_ni(pwr_dn_ni),
  .lane_drv_en_o(lane_drv_en_o), .load_w(load_w), .cap_w(cap_w),
  .clk_ser_w(clk_ser_w), .shadow_w(shadow_w)
);

// File: tb/pix_ser7_tx_tb.sv
module pix_ser7_tx_tb;
  localparam int LANES = 3;
  localparam int BITS  = 7;
  localparam int WORD  = LANES * BITS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pix = 1'b0;
  logic            sel = 1'b0;
  logic            pdn = 1'b1;
  logic [WORD-1:0] data = '0;
  wire  [LANES-1:0] lane;
  wire             clk_lane;
  wire             drv_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [WORD-1:0] cap_word;
  bit              cap_valid;

  always #10 clk = ~clk;

  pix_ser7_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_clk_i(pix), .strobe_sel_i(sel),
    .pwr_dn_ni(pdn), .data_i(data), .lane_o(lane), .clk_lane_o(clk_lane),
    .lane_drv_en_o(drv_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; pix = 1'b0; data = '0; pdn = 1'b1; sel = s;
    repeat (3) @(negedge clk);
    chk(drv_en === 1'b0, "R8", "drv_en in reset", 32'(drv_en), 0);
    rst_n = 1'b1;
    cap_valid = 1'b0;
    cap_word  = '0;
  endtask

  // one pixel period: word w before the rising edge, ~w before the falling edge
  task automatic frame(input logic [WORD-1:0] w, input logic p);
    bit              en_exp = p && cap_valid;
    logic [WORD-1:0] exp_w  = cap_word;
    logic [WORD-1:0] got_w  = '0;
    logic [BITS-1:0] got_c  = '0;
    bit              en_ok  = 1'b1;
    string           en_tag;
    for (int ph = 0; ph < BITS; ph++) begin
      @(negedge clk);
      pix = (ph < 4);
      if (ph == 0) begin data = w; pdn = p; end
      if (ph == 2) data = ~w;
      @(posedge clk); #5;
      if (drv_en !== en_exp) en_ok = 1'b0;
      for (int l = 0; l < LANES; l++) got_w[l*BITS+ph] = lane[l];
      got_c[ph] = clk_lane;
    end
    en_tag = !p ? "R6" : (!cap_valid ? "R7" : "R8");
    chk(en_ok, en_tag, "drv_en over period", 32'(!en_exp), 32'(en_exp));
    if (en_exp) begin
      if (sel) chk(got_w === exp_w, "R1 R2 R4 R9", "rise word", 32'(got_w), 32'(exp_w));
      else     chk(got_w === exp_w, "R1 R2 R5", "fall word", 32'(got_w), 32'(exp_w));
      chk(got_c === 7'b0001111, "R3", "clock lane", 32'(got_c), 32'h0f);
    end
    cap_valid = p;
    cap_word  = sel ? w : ~w;
  endtask

  task automatic sweep(input logic s);
    do_reset(s);
    for (int b = 0; b < WORD; b++) frame(WORD'(1) << b, 1'b1);
    frame(21'h155555, 1'b1);
    frame(21'h0aaaaa, 1'b1);
    frame('1, 1'b1);
    frame('0, 1'b1);
    frame(21'h12d6b3, 1'b0);   // powered down, R6
    frame(21'h0f0f0f, 1'b0);
    frame(21'h1c3c5a, 1'b1);   // release, still undriven, R7
    frame(21'h03a5c7, 1'b1);
    frame(21'h1e1e1e, 1'b1);
  endtask

  initial begin
    sweep(1'b1);
    sweep(1'b0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule